// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter of a 16-bit processor whose instructions are each one halfword long, and it chooses the next counter value every time an instruction retires. The decode stage presents a two-bit instruction kind, the 4-bit condition field, the 8-bit signed branch offset, the current N/Z/C/V flags and, for instructions that write the counter explicitly, the value to write. From these the unit either steps to the next halfword, jumps to a PC-relative target when the condition holds, loads the explicit value, or enters a sticky halted state that stops instruction fetch.

The unit also computes the PC-relative address for the load-address instruction: the counter with its two low bits cleared, plus an 8-bit unsigned immediate scaled by four. The register file, ALU and memory sit outside the block. All interfaces are plain control and status pins. There is no stream handshake, so no back-pressure applies. The retire strobe `exec_i` is the only pacing input, and the counter moves only on cycles where it is high.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_o` is 0x0000, `taken_o` and `halted_o` are 0, and `fetch_req_o` is 1.
- R2: For kind 0 (sequential) with `exec_i` high, `pc_o` becomes `pc_o + 2` after the clock edge, wrapping modulo 2^16 (0xFFFE goes to 0x0000).
- R3: For kind 1 (conditional branch) whose condition holds, `pc_o` becomes `pc_o` plus the signed offset shifted left by one, modulo 2^16. Offset 0x7F gives +254 and offset 0x80 gives -256. When the condition fails, the step is +2.
- R4: `flags_i` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R5: Condition codes 14 and 15 are never taken, and the branch steps by +2 whatever the flags.
- R6: For kind 2 (explicit write), `pc_o` becomes `wr_pc_i` after the clock edge, replacing the +2 step.
- R7: `taken_o` is 1 for exactly the cycle after an update that redirected the counter (a branch that was taken, or any kind-2 write). It is 0 after a sequential step, after a branch that was not taken, and on cycles where no instruction retires.
- R8: Kind 3 (halt) with `exec_i` high sets `halted_o` after the edge. `pc_o` keeps the address of the halt instruction and `fetch_req_o` goes to 0. Later retire strobes of any kind are ignored, and only reset clears the halted state.
- R9: `pcrel_o` equals `(pc_o & 0xFFFC) + (imm8_i << 2)` modulo 2^16. It is combinational from the current counter, so it reads the address of the instruction being executed.
- R10: With `exec_i` low, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | An instruction retires this cycle |
| kind_i | input | 2 | 0 sequential, 1 conditional branch, 2 explicit write, 3 halt |
| cond_i | input | 4 | Branch condition code |
| boff_i | input | 8 | Signed branch offset in halfwords |
| flags_i | input | 4 | {N, Z, C, V} |
| wr_pc_i | input | 16 | Value for an explicit counter write |
| imm8_i | input | 8 | Unsigned immediate for PC-relative address generation |
| pc_o | output | 16 | Registered program counter |
| taken_o | output | 1 | The last update redirected the counter |
| halted_o | output | 1 | The unit is halted |
| fetch_req_o | output | 1 | Instruction fetch is allowed |
| pcrel_o | output | 16 | PC-relative address result |

## Verification
The hardest states to reach from the ports are the wrap-around at the top of the address space and the halted state, which holds only until the next reset. The stimulus reaches the wrap with an explicit write to 0xFFFE followed by a sequential step, and it drives the backward branch limit from a counter that has first been moved well away from zero. Once halted, the unit is sent explicit writes and taken branches to show that it ignores them. It is then reset in the middle of the run to show that reset alone clears the halted state. All sixteen condition codes are swept against flag patterns chosen so that each relation appears both taken and not taken.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    K_SEQ     = 2'd0,
    K_BRANCH  = 2'd1,
    K_PCWRITE = 2'd2,
    K_HALT    = 2'd3
  } kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned INSN_BYTES = 2;
  localparam int unsigned CODE_W     = 4;
endpackage

// File: rtl/pcb_cond_eval.sv
module pcb_cond_eval
  import pcb_pkg::*;
(
  input  logic [CODE_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              hit_o
);
  logic sgn_eq;
  assign sgn_eq = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      4'd0:    hit_o = flags_i.z;
      4'd1:    hit_o = !flags_i.z;
      4'd2:    hit_o = flags_i.c;
      4'd3:    hit_o = !flags_i.c;
      4'd4:    hit_o = flags_i.n;
      4'd5:    hit_o = !flags_i.n;
      4'd6:    hit_o = flags_i.v;
      4'd7:    hit_o = !flags_i.v;
      4'd8:    hit_o = flags_i.c && !flags_i.z;
      4'd9:    hit_o = !flags_i.c || flags_i.z;
      4'd10:   hit_o = sgn_eq;
      4'd11:   hit_o = !sgn_eq;
      4'd12:   hit_o = !flags_i.z && sgn_eq;
      4'd13:   hit_o = flags_i.z || !sgn_eq;
      default: hit_o = 1'b0;  // R5: reserved codes never taken
    endcase
  end
endmodule

// File: rtl/pcb_next_pc.sv
module pcb_next_pc
  import pcb_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned OFFW = 8
) (
  input  logic [AW-1:0]   pc_i,
  input  kind_e           kind_i,
  input  logic            hit_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [AW-1:0]   wr_i,
  output logic [AW-1:0]   next_o,
  output logic            redirect_o
);
  localparam int unsigned SEXT_W = AW - OFFW - 1;

  logic [AW-1:0] step_pc;
  logic [AW-1:0] disp;
  logic [AW-1:0] target_pc;

  assign step_pc   = pc_i + AW'(INSN_BYTES);
  assign disp      = {{SEXT_W{off_i[OFFW-1]}}, off_i, 1'b0};
  assign target_pc = pc_i + disp;

  always_comb begin
    next_o     = step_pc;
    redirect_o = 1'b0;
    unique case (kind_i)
      K_BRANCH: begin
        if (hit_i) begin
          next_o     = target_pc;
          redirect_o = 1'b1;
        end
      end
      K_PCWRITE: begin
        next_o     = wr_i;
        redirect_o = 1'b1;
      end
      default: begin
        next_o     = step_pc;
        redirect_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pcb_pcrel.sv
module pcb_pcrel #(
  parameter int unsigned AW    = 16,
  parameter int unsigned IMMW  = 8,
  parameter int unsigned ALIGN = 2
) (
  input  logic [AW-1:0]   pc_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] base;
  logic [AW-1:0] imm_ext;

  assign base    = {pc_i[AW-1:ALIGN], {ALIGN{1'b0}}};
  assign imm_ext = {{(AW-IMMW){1'b0}}, imm_i};
  assign addr_o  = base + (imm_ext << ALIGN);
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned OFFW = 8,
  parameter int unsigned IMMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_i,
  input  logic [1:0]      kind_i,
  input  logic [3:0]      cond_i,
  input  logic [OFFW-1:0] boff_i,
  input  logic [3:0]      flags_i,
  input  logic [AW-1:0]   wr_pc_i,
  input  logic [IMMW-1:0] imm8_i,
  output logic [AW-1:0]   pc_o,
  output logic            taken_o,
  output logic            halted_o,
  output logic            fetch_req_o,
  output logic [AW-1:0]   pcrel_o
);
  kind_e         kind;
  flags_t        flg;
  logic          hit;
  logic [AW-1:0] next_pc;
  logic          redirect;
  logic [AW-1:0] pc_q;
  logic          halt_q;
  logic          taken_q;

  assign kind = kind_e'(kind_i);
  assign flg  = flags_t'(flags_i);

  pcb_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flg),
    .hit_o   (hit)
  );

  pcb_next_pc #(.AW(AW), .OFFW(OFFW)) u_next (
    .pc_i       (pc_q),
    .kind_i     (kind),
    .hit_i      (hit),
    .off_i      (boff_i),
    .wr_i       (wr_pc_i),
    .next_o     (next_pc),
    .redirect_o (redirect)
  );

  pcb_pcrel #(.AW(AW), .IMMW(IMMW), .ALIGN(2)) u_pcrel (
    .pc_i   (pc_q),
    .imm_i  (imm8_i),
    .addr_o (pcrel_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      halt_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      if (exec_i && !halt_q) begin
        if (kind == K_HALT) begin
          halt_q <= 1'b1;
        end else begin
          pc_q    <= next_pc;
          taken_q <= redirect;
        end
      end
    end
  end

  assign pc_o        = pc_q;
  assign taken_o     = taken_q;
  assign halted_o    = halt_q;
  assign fetch_req_o = !halt_q;

  AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> $stable(pc_o));  // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);  // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !halted_o && kind_i == 2'd0) |=> (pc_o == AW'($past(pc_o) + AW'(2))));  // R2
  AST_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !halted_o && kind_i == 2'd2) |=> (pc_o == $past(wr_pc_i)));  // R6
  AST_NEVER_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !halted_o && kind_i == 2'd1 && cond_i[3:1] == 3'b111)
      |=> (pc_o == AW'($past(pc_o) + AW'(2)) && !taken_o));  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(pc_o) && !taken_o));  // R10
endmodule

// File: tb/pc_branch_unit_tb.sv
`timescale 1ns/1ps
module pc_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [3:0]  cond_i = 4'd0;
  logic [7:0]  boff_i = 8'd0;
  logic [3:0]  flags_i = 4'd0;
  logic [15:0] wr_pc_i = 16'd0;
  logic [7:0]  imm8_i = 8'd0;
  logic [15:0] pc_o;
  logic        taken_o, halted_o, fetch_req_o;
  logic [15:0] pcrel_o;

  always #2 clk = ~clk;

  pc_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .kind_i(kind_i),
    .cond_i(cond_i), .boff_i(boff_i), .flags_i(flags_i), .wr_pc_i(wr_pc_i),
    .imm8_i(imm8_i), .pc_o(pc_o), .taken_o(taken_o), .halted_o(halted_o),
    .fetch_req_o(fetch_req_o), .pcrel_o(pcrel_o)
  );

  typedef struct {
    logic [15:0] pc;
    logic        taken;
    logic        halted;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] mpc = 16'd0;
  logic        mhalt = 1'b0;
  bit          done = 1'b0;

  function automatic logic cond_true(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return ~z;
      4'd2:  return cy;
      4'd3:  return ~cy;
      4'd4:  return n;
      4'd5:  return ~n;
      4'd6:  return v;
      4'd7:  return ~v;
      4'd8:  return cy & ~z;
      4'd9:  return ~cy | z;
      4'd10: return n ~^ v;
      4'd11: return n ^ v;
      4'd12: return ~z & (n ~^ v);
      4'd13: return z | (n ^ v);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic ex, input logic [1:0] k, input logic [3:0] c,
                      input logic [7:0] off, input logic [3:0] f,
                      input logic [15:0] w, input string tag);
    exp_t e;
    logic tk;
    @(negedge clk);
    exec_i = ex; kind_i = k; cond_i = c; boff_i = off; flags_i = f; wr_pc_i = w;
    tk = 1'b0;
    if (ex && !mhalt) begin
      case (k)
        2'd0: mpc = mpc + 16'd2;
        2'd1: begin
          if (cond_true(c, f)) begin
            mpc = mpc + {{7{off[7]}}, off, 1'b0};
            tk = 1'b1;
          end else mpc = mpc + 16'd2;
        end
        2'd2: begin mpc = w; tk = 1'b1; end
        default: mhalt = 1'b1;
      endcase
    end
    e.pc = mpc; e.taken = tk; e.halted = mhalt; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (pc_o !== e.pc || taken_o !== e.taken || halted_o !== e.halted ||
          fetch_req_o !== !e.halted) begin
        n_fail++;
        $display("FAIL %s: pc=%h taken=%b halted=%b req=%b expected pc=%h taken=%b halted=%b req=%b",
                 e.tag, pc_o, taken_o, halted_o, fetch_req_o, e.pc, e.taken, e.halted, !e.halted);
      end
    end
  end

  task automatic chk_pcrel(input logic [7:0] imm, input string tag);
    logic [15:0] expv;
    @(negedge clk);
    exec_i = 1'b0; imm8_i = imm;
    #1;
    expv = (mpc & 16'hFFFC) + ({8'd0, imm} << 2);
    n_chk++;
    if (pcrel_o !== expv) begin
      n_fail++;
      $display("FAIL %s: pcrel=%h expected %h", tag, pcrel_o, expv);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; exec_i = 1'b0;
    mpc = 16'd0; mhalt = 1'b0;
    #1;
    n_chk++;
    if (pc_o !== 16'd0 || taken_o !== 1'b0 || halted_o !== 1'b0 || fetch_req_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: pc=%h taken=%b halted=%b req=%b expected 0000 0 0 1",
               tag, pc_o, taken_o, halted_o, fetch_req_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    do_reset("R1 reset state");
    step(1'b0, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R1 first cycle after reset");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R2 sequential step");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R2 sequential step");
    step(1'b0, 2'd2, 4'd0, 8'd0, 4'd0, 16'h5555, "R10 idle hold");
    step(1'b0, 2'd1, 4'd0, 8'd10, 4'b0100, 16'd0, "R10 idle hold with branch");
    step(1'b1, 2'd2, 4'd0, 8'd0, 4'd0, 16'h1000, "R6 explicit write");
    step(1'b1, 2'd1, 4'd0, 8'h7F, 4'b0100, 16'd0, "R3 max forward +254");
    step(1'b1, 2'd1, 4'd0, 8'h80, 4'b0100, 16'd0, "R3 max backward -256");
    step(1'b1, 2'd1, 4'd0, 8'h80, 4'b0000, 16'd0, "R3 not taken steps +2");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R7 taken low after sequential");
    chk_pcrel(8'hFF, "R9 pcrel");
    step(1'b1, 2'd2, 4'd0, 8'd0, 4'd0, 16'h1236, "R6 write unaligned base");
    chk_pcrel(8'h01, "R9 pcrel clears low bits");
    step(1'b1, 2'd2, 4'd0, 8'd0, 4'd0, 16'hFFFE, "R6 write top");
    chk_pcrel(8'hFF, "R9 pcrel wraps");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R2 wrap to zero");
    step(1'b1, 2'd2, 4'd0, 8'd0, 4'd0, 16'h2000, "R6 write mid");
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f += 3) begin
        step(1'b1, 2'd1, c[3:0], 8'h04, f[3:0], 16'd0,
             (c >= 14) ? "R5 reserved condition" : "R4 condition sweep");
      end
      step(1'b1, 2'd1, c[3:0], 8'hFC, 4'b1111, 16'd0,
           (c >= 14) ? "R5 reserved all flags" : "R4 condition all flags");
    end
    step(1'b1, 2'd3, 4'd0, 8'd0, 4'd0, 16'd0, "R8 halt entered");
    step(1'b1, 2'd2, 4'd0, 8'd0, 4'd0, 16'h4444, "R8 write ignored");
    step(1'b1, 2'd1, 4'd0, 8'h10, 4'b0100, 16'd0, "R8 branch ignored");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R8 still halted");
    do_reset("R8 reset clears halt");
    step(1'b1, 2'd0, 4'd0, 8'd0, 4'd0, 16'd0, "R8 runs after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule